// File: doc/BRIEF.md
# Half-Duplex Collision, Backoff and Deferral Controller

This block sits beside a serial frame transmitter running at one clock per bit time. It decides when an attempt may begin, after an interframe gap of idle carrier, and watches the collision input while the frame goes out. On a collision it drives a fixed-length jam, waits out a randomized backoff of whole slot times, and then retries. When the attempt budget is spent, or the medium stays busy for too long, it gives up. At the end of every operation it leaves a set of held result flags for the host to read.

The framer tells the block when a new operation is accepted (`start_i`), when it is still inside preamble and delimiter (`pre_phase_i`), and when a frame completed without trouble (`done_i`). The block answers with a one-cycle `go_o` for each attempt, a `jam_o` level while the framer must send ones, and a one-cycle `eop_o` that closes the operation. `abort_o` rises with `eop_o` when the operation failed. A test-mode input shortens the gap, slot and deferral counts so that a bench can reach them quickly.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: The attempt budget comes from `retry_sel_i`: 2'b00 allows 16 attempts, 2'b01 allows 8, 2'b10 allows 4 and 2'b11 allows 1. When the jam of the collision that uses up the last attempt ends, `cerr_o` is set, and `eop_o` and `abort_o` pulse for one cycle in the cycle after the last jam cycle.
- R2: A collision seen while transmitting raises `coll_det_o` in the next cycle. `jam_o` is then high for exactly 32 consecutive cycles, and `coll_det_o` falls in the first cycle after the jam.
- R3: While `pre_phase_i` is high, a collision is remembered but `jam_o` stays low. Jam begins in the cycle after `pre_phase_i` is seen low.
- R4: A 12-bit pseudorandom register (seed 12'h5A3 after reset) advances every cycle unless `freeze_i` is high. After jam number n, the backoff count is the low min(n,10) bits of that register. The count falls by one per slot, so `go_o` comes K*S + G + 2 cycles after the last jam cycle, where K is the count, S the slot length and G the gap length.
- R5: With `bypass_bo_i` high there is no backoff, and `go_o` comes G + 1 cycles after the last jam cycle.
- R6: Once the block starts waiting, `go_o` pulses for one cycle after G consecutive cycles with `crs_i` low, counted from the first waiting cycle. Any busy cycle restarts the gap count.
- R7: Each busy carrier cycle while waiting sets `def_o`. The busy count restarts from zero every time waiting begins. With `defer_abort_en_i` high, the busy cycle that finds the count already at the limit D ends the operation with `exdef_o`, `eop_o` and `abort_o`, so busy carrier from the first waiting cycle gives `eop_o` D + 1 cycles after entry. With `defer_abort_en_i` low, deferral never ends the operation.
- R8: `test_mode_i` low gives G = 96, S = 512 and D = 24288. `test_mode_i` high gives G = 25, S = 8 and D = 242.
- R9: With `full_dup_i` high, `col_i` has no effect: `coll_det_o` and `jam_o` stay low, and the frame ends normally.
- R10: When an operation ends, `scol_o` is set if exactly one collision occurred and `mcol_o` if more than one. These flags are also set alongside `cerr_o`.
- R11: A collision first seen at bit index S or later, counting from 0 in the cycle `go_o` is high, sets `late_o`. The jam and retry sequence continues as for any other collision.
- R12: After reset all outputs are low. Accepting `start_i` while idle clears every result flag and the collision count in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst | input | 1 | Asynchronous reset, active high |
| start_i | input | 1 | New transmit operation accepted (used only while idle) |
| pre_phase_i | input | 1 | Framer is still sending preamble or delimiter |
| done_i | input | 1 | Framer finished the frame |
| col_i | input | 1 | Collision indication from the line |
| crs_i | input | 1 | Carrier sense |
| full_dup_i | input | 1 | Full-duplex mode, collision ignored |
| retry_sel_i | input | 2 | Attempt budget select |
| bypass_bo_i | input | 1 | Skip backoff after jam |
| defer_abort_en_i | input | 1 | Allow abort on excess deferral |
| test_mode_i | input | 1 | Shortened terminal counts |
| freeze_i | input | 1 | Pause the pseudorandom register |
| go_o | output | 1 | One-cycle start of an attempt |
| jam_o | output | 1 | Framer must send jam ones |
| abort_o | output | 1 | Operation failed (with eop_o) |
| eop_o | output | 1 | One-cycle end of operation |
| coll_det_o | output | 1 | Collision seen, held until the jam ends |
| late_o | output | 1 | Late collision occurred |
| scol_o | output | 1 | Exactly one collision |
| mcol_o | output | 1 | More than one collision |
| cerr_o | output | 1 | Attempt budget exhausted |
| def_o | output | 1 | Operation deferred at least once |
| exdef_o | output | 1 | Operation ended by excess deferral |

## Verification
The bench holds the random register frozen at its seed, so each backoff length is known. It then times every retry to the exact cycle: an off-by-one in the slot count or the gap count moves `go_o` by one cycle, and a mask that ignores the collision number gives the wrong count on the second retry. It also puts a collision inside preamble, where a controller that jams at once would raise `jam_o` early. It spreads more busy carrier than the deferral limit over two separate waits, which a cumulative deferral counter would wrongly abort. Finally, it checks the single-attempt budget, where an off-by-one in the attempt compare would retry once instead of setting `cerr_o`.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  localparam int NCOL_W  = 5;   // holds collision numbers up to 16
  localparam int BO_BITS = 10;  // backoff slot counter width
  localparam int RND_BITS = 12; // pseudorandom register width

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XMIT,
    ST_JAM,
    ST_BACKOFF
  } cbc_state_t;

  // Total attempts allowed for a given select code.
  function automatic logic [NCOL_W-1:0] attempt_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   return NCOL_W'(16);
      2'b01:   return NCOL_W'(8);
      2'b10:   return NCOL_W'(4);
      default: return NCOL_W'(1);
    endcase
  endfunction

  // Mask of the low min(n, BO_BITS) bits.
  function automatic logic [BO_BITS-1:0] backoff_mask(input logic [NCOL_W-1:0] n);
    logic [BO_BITS-1:0] m;
    for (int i = 0; i < BO_BITS; i++) m[i] = (i < int'(n));
    return m;
  endfunction

endpackage

// File: rtl/cbc_lfsr.sv
module cbc_lfsr #(
  parameter int W     = 12,
  parameter int OUT_W = 10,
  parameter int SEED  = 'h5A3,
  parameter logic [W-1:0] TAPS = 12'h829
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  output logic [OUT_W-1:0] q
);
  logic [W-1:0] st;
  logic         fb;

  assign fb = ^(st & TAPS);
  assign q  = st[OUT_W-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        st <= W'(SEED);
    else if (!hold) st <= {st[W-2:0], fb};
  end

  p_freeze_holds_r4: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(st));
  p_never_zero_r4: assert property (@(posedge clk) disable iff (rst)
    st != '0);
endmodule

// File: rtl/cbc_count.sv
module cbc_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                    q <= '0;
    else if (clr)               q <= '0;
    else if (en && q != '1)     q <= q + W'(1);
  end

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(q));
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));
endmodule

// File: rtl/csma_backoff_ctrl.sv
module csma_backoff_ctrl
  import cbc_pkg::*;
#(
  parameter int GAP_NORM   = 96,
  parameter int GAP_TEST   = 25,
  parameter int SLOT_NORM  = 512,
  parameter int SLOT_TEST  = 8,
  parameter int DEFER_NORM = 24288,
  parameter int DEFER_TEST = 242,
  parameter int JAM_BITS   = 32,
  parameter int RND_SEED   = 'h5A3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       pre_phase_i,
  input  logic       done_i,
  input  logic       col_i,
  input  logic       crs_i,
  input  logic       full_dup_i,
  input  logic [1:0] retry_sel_i,
  input  logic       bypass_bo_i,
  input  logic       defer_abort_en_i,
  input  logic       test_mode_i,
  input  logic       freeze_i,
  output logic       go_o,
  output logic       jam_o,
  output logic       abort_o,
  output logic       eop_o,
  output logic       coll_det_o,
  output logic       late_o,
  output logic       scol_o,
  output logic       mcol_o,
  output logic       cerr_o,
  output logic       def_o,
  output logic       exdef_o
);
  localparam int GW = $clog2(GAP_NORM + 1);
  localparam int SW = $clog2(SLOT_NORM + 1);
  localparam int DW = $clog2(DEFER_NORM + 1);

  cbc_state_t          state_q;
  logic [NCOL_W-1:0]   ncol_q;
  logic [BO_BITS-1:0]  bo_q;
  logic [BO_BITS-1:0]  rnd_low;
  logic coll_pend_q, cdet_q, late_q, scol_q, mcol_q, cerr_q, def_q, exdef_q;
  logic go_q, eop_q, abort_q;

  logic [GW-1:0] gap_q;
  logic [DW-1:0] dfr_q;
  logic [SW-1:0] age_q;
  logic [SW-1:0] tick_q;

  // Terminal counts picked by test mode
  logic [GW-1:0]     gap_last;
  logic [SW-1:0]     slot_len, slot_last, jam_last;
  logic [DW-1:0]     dfr_lim;
  logic [NCOL_W-1:0] limit;

  assign gap_last  = test_mode_i ? GW'(GAP_TEST - 1)  : GW'(GAP_NORM - 1);
  assign slot_len  = test_mode_i ? SW'(SLOT_TEST)     : SW'(SLOT_NORM);
  assign slot_last = test_mode_i ? SW'(SLOT_TEST - 1) : SW'(SLOT_NORM - 1);
  assign jam_last  = SW'(JAM_BITS - 1);
  assign dfr_lim   = test_mode_i ? DW'(DEFER_TEST)    : DW'(DEFER_NORM);
  assign limit     = attempt_limit(retry_sel_i);

  // Named internal events
  logic col_seen, jam_go, tx_ok, gap_done, dfr_busy, dfr_over;
  logic jam_end, out_of_tries, slot_end, bo_zero;

  assign col_seen     = (state_q == ST_XMIT) && col_i && !full_dup_i;
  assign jam_go       = (state_q == ST_XMIT) && (coll_pend_q || col_seen) && !pre_phase_i;
  assign tx_ok        = (state_q == ST_XMIT) && done_i && !(coll_pend_q || col_seen);
  assign gap_done     = (state_q == ST_WAIT) && !crs_i && (gap_q == gap_last);
  assign dfr_busy     = (state_q == ST_WAIT) && crs_i;
  assign dfr_over     = dfr_busy && defer_abort_en_i && (dfr_q == dfr_lim);
  assign jam_end      = (state_q == ST_JAM) && (tick_q == jam_last);
  assign out_of_tries = (ncol_q >= limit);
  assign slot_end     = (state_q == ST_BACKOFF) && (bo_q != '0) && (tick_q == slot_last);
  assign bo_zero      = (state_q == ST_BACKOFF) && (bo_q == '0);

  cbc_lfsr #(.W(RND_BITS), .OUT_W(BO_BITS), .SEED(RND_SEED)) u_rnd (
    .clk(clk), .rst(rst), .hold(freeze_i), .q(rnd_low));

  cbc_count #(.W(GW)) u_gap (.clk(clk), .rst(rst),
    .clr(state_q != ST_WAIT || crs_i), .en(1'b1), .q(gap_q));

  cbc_count #(.W(DW)) u_dfr (.clk(clk), .rst(rst),
    .clr(state_q != ST_WAIT), .en(crs_i), .q(dfr_q));

  cbc_count #(.W(SW)) u_age (.clk(clk), .rst(rst),
    .clr(state_q != ST_XMIT), .en(1'b1), .q(age_q));

  cbc_count #(.W(SW)) u_tick (.clk(clk), .rst(rst),
    .clr(!((state_q == ST_JAM) || (state_q == ST_BACKOFF && bo_q != '0)) || jam_end || slot_end),
    .en(1'b1), .q(tick_q));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ncol_q <= '0; bo_q <= '0;
      coll_pend_q <= 1'b0; cdet_q <= 1'b0; late_q <= 1'b0;
      scol_q <= 1'b0; mcol_q <= 1'b0; cerr_q <= 1'b0;
      def_q <= 1'b0; exdef_q <= 1'b0;
      go_q <= 1'b0; eop_q <= 1'b0; abort_q <= 1'b0;
    end else begin
      go_q <= 1'b0; eop_q <= 1'b0; abort_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          ncol_q <= '0; coll_pend_q <= 1'b0; cdet_q <= 1'b0; late_q <= 1'b0;
          scol_q <= 1'b0; mcol_q <= 1'b0; cerr_q <= 1'b0;
          def_q <= 1'b0; exdef_q <= 1'b0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (dfr_busy) def_q <= 1'b1;
          if (dfr_over) begin
            exdef_q <= 1'b1; eop_q <= 1'b1; abort_q <= 1'b1;
            state_q <= ST_IDLE;
          end else if (gap_done) begin
            go_q <= 1'b1;
            state_q <= ST_XMIT;
          end
        end
        ST_XMIT: begin
          if (col_seen) begin
            coll_pend_q <= 1'b1;
            cdet_q <= 1'b1;
            if (age_q >= slot_len) late_q <= 1'b1;
          end
          if (jam_go) begin
            coll_pend_q <= 1'b0;
            ncol_q <= ncol_q + NCOL_W'(1);
            state_q <= ST_JAM;
          end else if (tx_ok) begin
            eop_q <= 1'b1;
            scol_q <= (ncol_q == NCOL_W'(1));
            mcol_q <= (ncol_q > NCOL_W'(1));
            state_q <= ST_IDLE;
          end
        end
        ST_JAM: if (jam_end) begin
          cdet_q <= 1'b0;
          if (out_of_tries) begin
            cerr_q <= 1'b1; eop_q <= 1'b1; abort_q <= 1'b1;
            scol_q <= (ncol_q == NCOL_W'(1));
            mcol_q <= (ncol_q > NCOL_W'(1));
            state_q <= ST_IDLE;
          end else if (bypass_bo_i) begin
            state_q <= ST_WAIT;
          end else begin
            bo_q <= rnd_low & backoff_mask(ncol_q);
            state_q <= ST_BACKOFF;
          end
        end
        ST_BACKOFF: begin
          if (bo_zero) state_q <= ST_WAIT;
          else if (slot_end) bo_q <= bo_q - BO_BITS'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign go_o       = go_q;
  assign jam_o      = (state_q == ST_JAM);
  assign abort_o    = abort_q;
  assign eop_o      = eop_q;
  assign coll_det_o = cdet_q;
  assign late_o     = late_q;
  assign scol_o     = scol_q;
  assign mcol_o     = mcol_q;
  assign cerr_o     = cerr_q;
  assign def_o      = def_q;
  assign exdef_o    = exdef_q;

  p_tries_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> (ncol_q <= limit));
  p_abort_ends_r1: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> eop_o);
  p_jam_flagged_r2: assert property (@(posedge clk) disable iff (rst)
    jam_o |-> coll_det_o);
  p_no_jam_in_pre_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XMIT && pre_phase_i) |=> !jam_o);
  p_bo_down_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BACKOFF && bo_q != '0) |=> (bo_q <= $past(bo_q)));
  p_go_idle_line_r6: assert property (@(posedge clk) disable iff (rst)
    go_o |-> $past(!crs_i));
  p_exdef_def_r7: assert property (@(posedge clk) disable iff (rst)
    exdef_o |-> def_o);
  p_fdx_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XMIT && full_dup_i && !coll_pend_q) |=> !coll_det_o);
  p_col_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(scol_o && mcol_o));
  p_cerr_counted_r10: assert property (@(posedge clk) disable iff (rst)
    cerr_o |-> (scol_o || mcol_o));
endmodule

// File: tb/csma_backoff_ctrl_test.sv
module csma_backoff_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, pre_phase_i = 0, done_i = 0, col_i = 0, crs_i = 0;
  logic full_dup_i = 0, bypass_bo_i = 0, defer_abort_en_i = 0;
  logic test_mode_i = 1, freeze_i = 1;
  logic [1:0] retry_sel_i = 2'b00;
  logic go_o, jam_o, abort_o, eop_o, coll_det_o, late_o;
  logic scol_o, mcol_o, cerr_o, def_o, exdef_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  localparam int G = 25, S = 8, D = 242;

  always #10 clk = ~clk;

  csma_backoff_ctrl uut (
    .clk(clk), .rst(rst), .start_i(start_i), .pre_phase_i(pre_phase_i),
    .done_i(done_i), .col_i(col_i), .crs_i(crs_i), .full_dup_i(full_dup_i),
    .retry_sel_i(retry_sel_i), .bypass_bo_i(bypass_bo_i),
    .defer_abort_en_i(defer_abort_en_i), .test_mode_i(test_mode_i),
    .freeze_i(freeze_i), .go_o(go_o), .jam_o(jam_o), .abort_o(abort_o),
    .eop_o(eop_o), .coll_det_o(coll_det_o), .late_o(late_o),
    .scol_o(scol_o), .mcol_o(mcol_o), .cerr_o(cerr_o), .def_o(def_o),
    .exdef_o(exdef_o));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_op();
    start_i = 1; tick(); start_i = 0;
  endtask

  task automatic wait_go(output int n);
    n = 0;
    while (!go_o && n < 5000) begin tick(); n++; end
  endtask

  task automatic end_frame();
    done_i = 1; tick(); done_i = 0;
  endtask

  // Collision at the current go cycle; returns jam length and delay to next go/eop.
  task automatic collide(output int jl, output int d, output int cd);
    col_i = 1; tick(); col_i = 0;
    cd = coll_det_o;
    jl = 0;
    while (jam_o && jl < 100) begin jl++; tick(); end
    d = 1;
    while (!go_o && !eop_o && d < 5000) begin tick(); d++; end
  endtask

  task automatic t_reset();
    chk("R12", "go after reset", go_o, 0);
    chk("R12", "flags after reset",
        {jam_o, abort_o, eop_o, coll_det_o, late_o, scol_o, mcol_o, cerr_o, def_o, exdef_o}, 0);
  endtask

  task automatic t_clean();
    int n;
    retry_sel_i = 2'b00; start_op(); wait_go(n);
    chk("R6", "gap cycles test mode", n, G);
    chk("R8", "short gap in test mode", n, 25);
    end_frame();
    chk("R10", "eop on clean frame", eop_o, 1);
    chk("R10", "no collision flags", {scol_o, mcol_o, abort_o}, 0);
  endtask

  task automatic t_single_attempt();
    int n, jl, d, cd;
    retry_sel_i = 2'b11; start_op(); wait_go(n);
    collide(jl, d, cd);
    chk("R2", "coll_det after collision", cd, 1);
    chk("R2", "jam length", jl, 32);
    chk("R2", "coll_det after jam", coll_det_o, 0);
    chk("R1", "eop right after jam", d, 1);
    chk("R1", "cerr/abort", {cerr_o, abort_o, eop_o}, 3'b111);
    chk("R10", "single collision with cerr", {scol_o, mcol_o}, 2'b10);
    chk("R11", "early collision not late", late_o, 0);
  endtask

  task automatic t_four_attempts();
    int n, jl, d, cd;
    retry_sel_i = 2'b10; bypass_bo_i = 0; start_op(); wait_go(n);
    collide(jl, d, cd);
    chk("R4", "backoff after first collision (K=1)", d, 1*S + G + 2);
    collide(jl, d, cd);
    chk("R4", "backoff after second collision (K=3)", d, 3*S + G + 2);
    collide(jl, d, cd);
    chk("R4", "backoff after third collision (K=3)", d, 3*S + G + 2);
    collide(jl, d, cd);
    chk("R1", "fourth collision ends op", d, 1);
    chk("R1", "cerr after 4 attempts", {cerr_o, abort_o}, 2'b11);
    chk("R10", "multiple collision flag", {scol_o, mcol_o}, 2'b01);
  endtask

  task automatic t_bypass();
    int n, jl, d, cd;
    retry_sel_i = 2'b00; bypass_bo_i = 1; start_op(); wait_go(n);
    collide(jl, d, cd);
    chk("R5", "retry after gap only", d, G + 1);
    end_frame();
    chk("R10", "single collision then success", {eop_o, scol_o, mcol_o, cerr_o}, 4'b1100);
    bypass_bo_i = 0;
  endtask

  task automatic t_preamble();
    int n, jl;
    retry_sel_i = 2'b11; start_op(); wait_go(n);
    pre_phase_i = 1; col_i = 1; tick(); col_i = 0;
    chk("R3", "coll_det during preamble", coll_det_o, 1);
    chk("R3", "no jam during preamble", jam_o, 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3", "still no jam in preamble", jam_o, 0);
    end
    pre_phase_i = 0; tick();
    chk("R3", "jam after preamble ends", jam_o, 1);
    jl = 0;
    while (jam_o && jl < 100) begin jl++; tick(); end
    chk("R2", "jam length after preamble", jl, 32);
    chk("R1", "cerr after preamble collision", {eop_o, cerr_o}, 2'b11);
  endtask

  task automatic t_full_duplex();
    int n;
    retry_sel_i = 2'b00; full_dup_i = 1; start_op(); wait_go(n);
    col_i = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9", "collision ignored", {coll_det_o, jam_o}, 0);
    end
    col_i = 0; end_frame();
    chk("R9", "frame ends normally", {eop_o, scol_o, abort_o}, 3'b100);
    full_dup_i = 0;
  endtask

  task automatic t_late();
    int n, jl;
    retry_sel_i = 2'b11; start_op(); wait_go(n);
    for (int i = 0; i < 10; i++) tick();
    col_i = 1; tick(); col_i = 0;
    chk("R11", "late collision flag", late_o, 1);
    jl = 0;
    while (jam_o && jl < 100) begin jl++; tick(); end
    chk("R11", "late collision still jams", jl, 32);
  endtask

  task automatic t_clear();
    int n;
    start_op();
    chk("R12", "start clears flags", {late_o, cerr_o, scol_o, mcol_o, abort_o}, 0);
    wait_go(n); end_frame();
  endtask

  task automatic t_exdef();
    int n;
    defer_abort_en_i = 1; retry_sel_i = 2'b00; crs_i = 1; start_op();
    n = 0;
    while (!eop_o && n < 5000) begin tick(); n++; end
    chk("R7", "excess deferral timing", n, D + 1);
    chk("R7", "exdef/abort/def", {exdef_o, abort_o, def_o}, 3'b111);
    crs_i = 0; tick();
  endtask

  task automatic t_defer_forever();
    int n, seen;
    defer_abort_en_i = 0; crs_i = 1; start_op();
    seen = 0;
    for (int i = 0; i < 400; i++) begin tick(); seen |= int'(eop_o); end
    chk("R7", "no abort when disabled", seen, 0);
    crs_i = 0; wait_go(n);
    chk("R6", "gap restarts after busy", n, G);
    end_frame();
    chk("R7", "deferred but not excess", {def_o, exdef_o}, 2'b10);
  endtask

  task automatic t_defer_split();
    int n, seen;
    defer_abort_en_i = 1; bypass_bo_i = 1; retry_sel_i = 2'b00;
    crs_i = 1; start_op(); seen = 0;
    for (int i = 0; i < 200; i++) begin tick(); seen |= int'(eop_o); end
    crs_i = 0; wait_go(n);
    col_i = 1; tick(); col_i = 0;
    while (jam_o) tick();
    crs_i = 1;
    for (int i = 0; i < 200; i++) begin tick(); seen |= int'(eop_o); end
    crs_i = 0; wait_go(n);
    chk("R7", "deferral not cumulative", seen, 0);
    chk("R6", "retry after gap", n, G);
    end_frame();
    chk("R7", "flags after split deferral", {def_o, exdef_o, scol_o}, 3'b101);
    bypass_bo_i = 0; defer_abort_en_i = 0;
  endtask

  task automatic t_normal_gap();
    int n;
    test_mode_i = 0; start_op(); wait_go(n);
    chk("R8", "normal gap length", n, 96);
    end_frame(); test_mode_i = 1;
  endtask

  task automatic t_random();
    int n, jl, d, cd;
    freeze_i = 0; retry_sel_i = 2'b00; start_op(); wait_go(n);
    collide(jl, d, cd);
    chk("R4", "unfrozen first backoff is 0 or 1 slot", int'(d == G + 2 || d == S + G + 2), 1);
    end_frame();
    chk("R10", "single collision", scol_o, 1);
    freeze_i = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all R tags): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_clean();
    t_single_attempt();
    t_four_attempts();
    t_bypass();
    t_preamble();
    t_full_duplex();
    t_late();
    t_clear();
    t_exdef();
    t_defer_forever();
    t_defer_split();
    t_normal_gap();
    t_random();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule